// File: doc/BRIEF.md
# USB Root-Hub Port Status and Control Register

This block holds the status and control word for each downstream port of a two-port USB host root hub. Each port has its own 32-bit register with its own read and write port. The low half of the word reports and controls live port state: connection, enable, suspend, over-current, reset in progress, power and low-speed attachment. The upper half holds sticky change flags. Only hardware events set these flags, and software clears one by writing a 1 to it.

A millisecond tick input paces two timed sequences in each port. The first is a port reset that software starts and that ends on its own after a set number of ticks. The second is a resume sequence: a resume drive period, a one-clock end-of-packet marker, then a resynchronisation wait. The completion flags assert on the exact tick that ends each sequence. Three outputs per port tell the line driver when to signal reset, resume and the end-of-packet. Tick counts are parameters, so a testbench can shorten them.

Top module: `rh_port_status`

## Requirements
- R1: After reset every bit of both port registers reads 0 and no drive output is active.
- R2: Bits 31:21, 15:10 and 7:5 always read 0, and a write of ones to only those bits changes nothing.
- R3: Bit 0 (connected) follows the attach input one clock later. Bit 16 sets whenever bit 0 changes. Bit 9 reads 1 while a low-speed device is attached.
- R4: Writing 1 to any of bits 20:16 clears that flag, and writing 0 leaves it unchanged. A hardware set in the same clock wins over the clear.
- R5: A write of 1 to bit 8 powers the port. A write of 1 to bit 9 removes power and disables the port. A write of 1 to bit 1 enables a connected port, a write of 1 to bit 0 disables it, and a write of 1 to bit 2 suspends an enabled port.
- R6: A write of 1 to bit 4 on a connected, powered port sets bit 4 and drives `port_rst_o` for RESET_TICKS ticks. On the last tick bit 4 clears, bit 20 sets and bit 1 takes the connect state.
- R7: A write of 1 to bit 3 on a suspended port drives `resume_drv_o` for RESUME_TICKS ticks. `resume_eop_o` is then high for exactly one clock, and RESYNC_TICKS ticks follow. Only on the last of these does bit 2 clear and bit 18 set.
- R8: Bit 18 is cleared in the same clock that bit 20 becomes set.
- R9: Bit 17 sets only when hardware clears bit 1 (disconnect, or over-current rising). Disabling by software or by power removal leaves it at 0.
- R10: With per-port over-current, bit 3 follows the over-current input one clock later and bit 19 sets on each change. A rising over-current on an enabled port clears bit 1.
- R11: With per-port over-current turned off, the over-current input is ignored: bits 3 and 19 stay 0 and the enable is kept.
- R12: Activity on one port never changes the other port's register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-clock pulse per millisecond |
| wr_en | input | NPORT | Per-port register write strobe |
| wr_data | input | 32*NPORT | Write data, port p in bits 32p+31:32p |
| rd_data | output | 32*NPORT | Register read value, same packing |
| attach_i | input | NPORT | Device present on the port |
| lowspeed_i | input | NPORT | Attached device is low speed |
| ovc_i | input | NPORT | Over-current condition on the port |
| port_rst_o | output | NPORT | Drive reset signalling |
| resume_drv_o | output | NPORT | Drive resume signalling |
| resume_eop_o | output | NPORT | One-clock end-of-packet after resume |

## Verification
The assertions assume that `ms_tick` never arrives in the same clock as the write that starts a timed sequence. They also assume that no tick lands in the single end-of-packet clock. Both cases would shift a count by one tick. The bench spaces its ticks away from its writes, and it changes attach and over-current only in clocks with no write or tick. The over-current sweep steps through every clear mask on a fixed set of raised flags.

// File: rtl/rh_port_pkg.sv
// Shared field positions and sequencer states for the root-hub port register.
// Assumes a 32-bit register word per port.
package rh_port_pkg;
    localparam int BIT_CONN   = 0;
    localparam int BIT_EN     = 1;
    localparam int BIT_SUSP   = 2;
    localparam int BIT_OCI    = 3;
    localparam int BIT_RST    = 4;
    localparam int BIT_PWR    = 8;
    localparam int BIT_LS     = 9;
    localparam int CHG_LO     = 16;
    localparam int CHG_HI     = 20;
    localparam int CHG_W      = CHG_HI - CHG_LO + 1;
    // change flag index inside the flag vector
    localparam int C_CONN = 0;
    localparam int C_EN   = 1;
    localparam int C_SUSP = 2;
    localparam int C_OC   = 3;
    localparam int C_RST  = 4;

    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_DRIVE  = 2'd1,
        RS_EOP    = 2'd2,
        RS_RESYNC = 2'd3
    } res_state_t;
endpackage

// File: rtl/rh_tick_timer.sv
// Counts LIMIT millisecond ticks after a start pulse; done pulses
// combinationally on the final tick. Assumes start and tick never coincide.
module rh_tick_timer #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic abort_i,
    input  logic tick_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign done_o = busy_o & tick_i & ~abort_i & (cnt == CW'(LIMIT - 1));

    // Track the running state and tick count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt    <= '0;
        end else if (abort_i) begin
            busy_o <= 1'b0;
        end else if (start_i) begin
            busy_o <= 1'b1;
            cnt    <= '0;
        end else if (done_o) begin
            busy_o <= 1'b0;
        end else if (busy_o && tick_i) begin
            cnt <= cnt + CW'(1);
        end
    end

    a_r6_start_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (cnt == '0));
    a_r6_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
endmodule

// File: rtl/rh_resume_seq.sv
// Resume sequencer: drive for DRIVE_TICKS, one end-of-packet clock, then a
// resync wait of SYNC_TICKS. Assumes no tick during the end-of-packet clock.
module rh_resume_seq #(
    parameter int DRIVE_TICKS = 20,
    parameter int SYNC_TICKS  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic abort_i,
    input  logic tick_i,
    output logic busy_o,
    output logic drv_o,
    output logic eop_o,
    output logic done_o
);
    import rh_port_pkg::*;

    res_state_t state;
    logic       drv_busy, drv_done, sync_busy, sync_done;
    logic       drv_start, sync_start;

    assign drv_start  = start_i & (state == RS_IDLE) & ~abort_i;
    assign sync_start = (state == RS_EOP) & ~abort_i;

    rh_tick_timer #(.LIMIT(DRIVE_TICKS)) u_drive (
        .clk(clk), .rst_n(rst_n), .start_i(drv_start), .abort_i(abort_i),
        .tick_i(tick_i), .busy_o(drv_busy), .done_o(drv_done));

    rh_tick_timer #(.LIMIT(SYNC_TICKS)) u_sync (
        .clk(clk), .rst_n(rst_n), .start_i(sync_start), .abort_i(abort_i),
        .tick_i(tick_i), .busy_o(sync_busy), .done_o(sync_done));

    assign busy_o = (state != RS_IDLE);
    assign drv_o  = (state == RS_DRIVE);
    assign eop_o  = (state == RS_EOP);
    assign done_o = (state == RS_RESYNC) & sync_done;

    // Step through the resume phases.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_i) begin
            state <= RS_IDLE;
        end else begin
            case (state)
                RS_IDLE:   if (start_i)   state <= RS_DRIVE;
                RS_DRIVE:  if (drv_done)  state <= RS_EOP;
                RS_EOP:                   state <= RS_RESYNC;
                RS_RESYNC: if (sync_done) state <= RS_IDLE;
                default:                  state <= RS_IDLE;
            endcase
        end
    end

    a_r7_eop_single: assert property (@(posedge clk) disable iff (!rst_n)
        eop_o |=> !eop_o);
    a_r7_drive_timer: assert property (@(posedge clk) disable iff (!rst_n)
        drv_o == drv_busy);
    a_r7_sync_timer: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_RESYNC) == sync_busy);
endmodule

// File: rtl/rh_port_core.sv
// One port's status/control word: live state, sticky change flags with
// write-1-to-clear, reset timer and resume sequencer. Inputs are synchronous.
module rh_port_core #(
    parameter int RESET_TICKS  = 10,
    parameter int RESUME_TICKS = 20,
    parameter int RESYNC_TICKS = 3,
    parameter bit PER_PORT_OC  = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        wr_en_i,
    input  logic [31:0] wr_data_i,
    input  logic        attach_i,
    input  logic        lowspeed_i,
    input  logic        ovc_i,
    output logic [31:0] rd_data_o,
    output logic        rst_drv_o,
    output logic        res_drv_o,
    output logic        res_eop_o
);
    import rh_port_pkg::*;

    logic              conn, en, susp, oci, pwr, ls;
    logic [CHG_W-1:0]  flg;
    logic              en_n, susp_n, pwr_n;
    logic [CHG_W-1:0]  flg_n;
    logic [31:0]       w;
    logic              rst, rst_start, rst_done;
    logic              res_busy, res_start, res_abort, res_done;
    logic              disc, oc_rise, oc_chg;
    logic              unused_bits;

    assign w           = wr_en_i ? wr_data_i : 32'd0;
    assign unused_bits = ^{w[31:21], w[15:10], w[7:5]};
    assign disc        = conn & ~attach_i;
    assign oc_rise     = PER_PORT_OC & ovc_i & ~oci;
    assign oc_chg      = PER_PORT_OC & (ovc_i ^ oci);
    assign rst_start   = w[BIT_RST] & conn & pwr & ~rst;
    assign res_start   = w[BIT_OCI] & susp & ~res_busy & ~rst;
    assign res_abort   = rst_start | disc | w[BIT_CONN] | w[BIT_LS];

    rh_tick_timer #(.LIMIT(RESET_TICKS)) u_rst_timer (
        .clk(clk), .rst_n(rst_n), .start_i(rst_start), .abort_i(1'b0),
        .tick_i(tick_i), .busy_o(rst), .done_o(rst_done));

    rh_resume_seq #(.DRIVE_TICKS(RESUME_TICKS), .SYNC_TICKS(RESYNC_TICKS)) u_resume (
        .clk(clk), .rst_n(rst_n), .start_i(res_start), .abort_i(res_abort),
        .tick_i(tick_i), .busy_o(res_busy), .drv_o(res_drv_o),
        .eop_o(res_eop_o), .done_o(res_done));

    // Next-state of control bits and change flags; hardware sets go last.
    always_comb begin
        en_n   = en;
        susp_n = susp;
        pwr_n  = pwr;
        flg_n  = flg & ~w[CHG_HI:CHG_LO];
        if (w[BIT_PWR])                            pwr_n = 1'b1;
        if (w[BIT_EN] && conn)                     en_n = 1'b1;
        if (w[BIT_SUSP] && en && !rst && !res_busy) susp_n = 1'b1;
        if (w[BIT_CONN]) begin
            en_n   = 1'b0;
            susp_n = 1'b0;
        end
        if (w[BIT_LS]) begin
            pwr_n  = 1'b0;
            en_n   = 1'b0;
            susp_n = 1'b0;
        end
        if (rst_start) susp_n = 1'b0;
        if (res_done) begin
            susp_n       = 1'b0;
            flg_n[C_SUSP] = 1'b1;
        end
        if (rst_done) begin
            en_n          = conn;
            susp_n        = 1'b0;
            flg_n[C_RST]  = 1'b1;
            flg_n[C_SUSP] = 1'b0;
        end
        if (attach_i != conn) flg_n[C_CONN] = 1'b1;
        if (oc_chg)           flg_n[C_OC]   = 1'b1;
        if (disc) susp_n = 1'b0;
        if (disc || oc_rise) begin
            if (en) flg_n[C_EN] = 1'b1;
            en_n = 1'b0;
        end
    end

    // Register live status and the change flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conn <= 1'b0;
            en   <= 1'b0;
            susp <= 1'b0;
            oci  <= 1'b0;
            pwr  <= 1'b0;
            ls   <= 1'b0;
            flg  <= '0;
        end else begin
            conn <= attach_i;
            ls   <= attach_i & lowspeed_i;
            oci  <= PER_PORT_OC & ovc_i;
            en   <= en_n;
            susp <= susp_n;
            pwr  <= pwr_n;
            flg  <= flg_n;
        end
    end

    // Assemble the read word; unlisted bits stay zero.
    always_comb begin
        rd_data_o                  = 32'd0;
        rd_data_o[BIT_CONN]        = conn;
        rd_data_o[BIT_EN]          = en;
        rd_data_o[BIT_SUSP]        = susp;
        rd_data_o[BIT_OCI]         = oci;
        rd_data_o[BIT_RST]         = rst;
        rd_data_o[BIT_PWR]         = pwr;
        rd_data_o[BIT_LS]          = ls;
        rd_data_o[CHG_HI:CHG_LO]   = flg;
    end

    assign rst_drv_o = rst;

    a_r9_pesc_hw_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flg[C_EN]) |-> $fell(en));
    a_r8_prsc_clears_pssc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flg[C_RST]) |-> !flg[C_SUSP]);
    a_r6_reset_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst) |-> flg[C_RST]);
    a_r7_resume_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flg[C_SUSP]) |-> $fell(susp));
    a_r11_no_oc: assert property (@(posedge clk) disable iff (!rst_n)
        !PER_PORT_OC |-> (!oci && !flg[C_OC]));
endmodule

// File: rtl/rh_port_status.sv
// Top: replicates the per-port status register for NPORT downstream ports.
// Assumes all event inputs are already synchronous to clk.
module rh_port_status #(
    parameter int NPORT        = 2,
    parameter int RESET_TICKS  = 10,
    parameter int RESUME_TICKS = 20,
    parameter int RESYNC_TICKS = 3,
    parameter bit PER_PORT_OC  = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ms_tick,
    input  logic [NPORT-1:0]    wr_en,
    input  logic [NPORT*32-1:0] wr_data,
    output logic [NPORT*32-1:0] rd_data,
    input  logic [NPORT-1:0]    attach_i,
    input  logic [NPORT-1:0]    lowspeed_i,
    input  logic [NPORT-1:0]    ovc_i,
    output logic [NPORT-1:0]    port_rst_o,
    output logic [NPORT-1:0]    resume_drv_o,
    output logic [NPORT-1:0]    resume_eop_o
);
    // One independent register per port (R12).
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        rh_port_core #(
            .RESET_TICKS(RESET_TICKS), .RESUME_TICKS(RESUME_TICKS),
            .RESYNC_TICKS(RESYNC_TICKS), .PER_PORT_OC(PER_PORT_OC)
        ) u_core (
            .clk(clk), .rst_n(rst_n), .tick_i(ms_tick),
            .wr_en_i(wr_en[p]), .wr_data_i(wr_data[p*32 +: 32]),
            .attach_i(attach_i[p]), .lowspeed_i(lowspeed_i[p]), .ovc_i(ovc_i[p]),
            .rd_data_o(rd_data[p*32 +: 32]), .rst_drv_o(port_rst_o[p]),
            .res_drv_o(resume_drv_o[p]), .res_eop_o(resume_eop_o[p]));
    end
endmodule

// File: tb/rh_port_status_bench.sv
`timescale 1ns/1ps
module rh_port_status_bench;
    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ms_tick = 1'b0;
    logic [NP-1:0] wr_en = '0, attach = '0, lows = '0, ovc = '0;
    logic [NP*32-1:0] wr_data = '0, rd_data;
    logic [NP-1:0] prst, rdrv, reop;

    logic [NP-1:0] g_wr_en = '0, g_attach = '0, g_ovc = '0;
    logic [NP*32-1:0] g_wr_data = '0, g_rd;
    logic [NP-1:0] g_prst, g_rdrv, g_reop;

    int vecs = 0, errs = 0;
    logic [31:0] snap;

    always #4 clk = ~clk;

    rh_port_status u_rh_port_status (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .attach_i(attach),
        .lowspeed_i(lows), .ovc_i(ovc), .port_rst_o(prst),
        .resume_drv_o(rdrv), .resume_eop_o(reop));

    rh_port_status #(.PER_PORT_OC(1'b0)) u_rh_port_status_gang (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .wr_en(g_wr_en),
        .wr_data(g_wr_data), .rd_data(g_rd), .attach_i(g_attach),
        .lowspeed_i(2'b00), .ovc_i(g_ovc), .port_rst_o(g_prst),
        .resume_drv_o(g_rdrv), .resume_eop_o(g_reop));

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        vecs++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] rd(input int p);
        return rd_data[p*32 +: 32];
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input int p, input logic [31:0] d);
        @(negedge clk);
        wr_en[p] = 1'b1;
        wr_data[p*32 +: 32] = d;
        @(negedge clk);
        wr_en[p] = 1'b0;
        wr_data[p*32 +: 32] = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
        end
    endtask

    task automatic do_reset();
        attach = '0; lows = '0; ovc = '0; g_attach = '0; g_ovc = '0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        // R4/R10/R9 sweep over every clear mask on port 1
        for (int m = 0; m < 32; m++) begin
            do_reset();
            attach[1] = 1'b1; step();
            wr(1, 32'h100);
            wr(1, 32'h10);
            ticks(10);
            chk("R6 sweep reset end", rd(1), 32'h0011_0103);
            ovc[1] = 1'b1; step();
            chk("R10 oc rise", rd(1), 32'h001B_0109);
            ovc[1] = 1'b0; step();
            chk("R10 oc fall", rd(1), 32'h001B_0101);
            wr(1, 32'(m) << 16);
            chk("R4 w1c mask", rd(1), 32'h0000_0101 | ((32'h1B & ~32'(m)) << 16));
        end

        do_reset();
        chk("R1 port0 zero", rd(0), 32'h0);
        chk("R1 port1 zero", rd(1), 32'h0);
        chk("R1 drives idle", {29'd0, |prst, |rdrv, |reop}, 32'h0);

        attach[0] = 1'b1; lows[0] = 1'b1; step();
        chk("R3 connect lowspeed", rd(0), 32'h0001_0201);
        wr(0, 32'h0);
        chk("R4 write zero keeps", rd(0), 32'h0001_0201);
        wr(0, 32'h0001_0000);
        chk("R4 clear csc", rd(0), 32'h0000_0201);
        wr(0, 32'h100);
        chk("R5 power on", rd(0), 32'h0000_0301);
        wr(0, 32'h10);
        chk("R6 reset active", rd(0), 32'h0000_0311);
        chk("R6 reset drive", {31'd0, prst[0]}, 32'h1);
        ticks(9);
        chk("R6 still resetting", rd(0), 32'h0000_0311);
        ticks(1);
        chk("R6 reset done", rd(0), 32'h0010_0303);
        chk("R6 drive off", {31'd0, prst[0]}, 32'h0);
        wr(0, 32'hFFE0_FCE0);
        chk("R2 reserved write", rd(0), 32'h0010_0303);
        snap = rd(0);

        attach[1] = 1'b1; step();
        wr(1, 32'h100);
        wr(1, 32'h10);
        ticks(10);
        wr(1, 32'h001F_0000);
        chk("R4 clear all", rd(1), 32'h0000_0103);
        wr(1, 32'h4);
        chk("R5 suspend", rd(1), 32'h0000_0107);
        wr(1, 32'h8);
        chk("R7 resume drive", {31'd0, rdrv[1]}, 32'h1);
        ticks(19);
        chk("R7 drive held", {30'd0, rdrv[1], reop[1]}, 32'h2);
        ticks(1);
        chk("R7 eop", {30'd0, rdrv[1], reop[1]}, 32'h1);
        step();
        chk("R7 eop one clock", {30'd0, rdrv[1], reop[1]}, 32'h0);
        ticks(2);
        chk("R7 resync wait", rd(1), 32'h0000_0107);
        ticks(1);
        chk("R7 resume done", rd(1), 32'h0004_0103);

        wr(1, 32'h10);
        ticks(10);
        chk("R8 reset clears pssc", rd(1), 32'h0010_0103);

        wr(1, 32'h1);
        chk("R9 sw disable", rd(1), 32'h0010_0101);
        wr(1, 32'h2);
        chk("R5 sw enable", rd(1), 32'h0010_0103);
        wr(1, 32'h200);
        chk("R9 power off", rd(1), 32'h0010_0001);
        wr(1, 32'h100);
        wr(1, 32'h2);
        chk("R5 re-enable", rd(1), 32'h0010_0103);
        attach[1] = 1'b0; step();
        chk("R9 disconnect", rd(1), 32'h0013_0100);

        chk("R12 port0 untouched", rd(0), snap);

        // R11: over-current ignored when not reported per port
        g_attach[0] = 1'b1; step();
        @(negedge clk); g_wr_en[0] = 1'b1; g_wr_data[31:0] = 32'h100;
        @(negedge clk); g_wr_data[31:0] = 32'h10;
        @(negedge clk); g_wr_en[0] = 1'b0; g_wr_data[31:0] = '0;
        ticks(10);
        chk("R11 gang enabled", g_rd[31:0], 32'h0011_0103);
        g_ovc[0] = 1'b1; step(); step();
        chk("R11 oc ignored", g_rd[31:0], 32'h0011_0103);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule